// File: doc/BRIEF.md
# Execute-Stage Next-PC Select and Wrong-Path Kill

This block chooses the next fetch address of a five-stage in-order pipeline whose control transfers resolve in the execute stage. Each cycle it decodes the control-transfer kind of the instruction in execute and, for conditional branches, tests the source register against zero. From that it picks one of three sources: the sequential address (fetch PC + 4), a PC-relative target (execute next-PC + sign-extended displacement), or a register-indirect target (the source register value).

When a transfer is taken, the instruction fetched sequentially behind it is already in decode. A two-state machine, with states `ST_RUN` and `ST_KILL`, remembers the redirect and raises `squash` while that instruction sits in execute. The rest of the pipeline uses `squash` to block that instruction's writes. A squashed or invalid instruction in execute never redirects and never produces a link. The link-writing jumps also present their return address (the execute next-PC) for writeback. Interrupts are not handled here.

The FSM has three transitions. `ST_RUN -> ST_KILL` happens on a taken redirect. `ST_KILL -> ST_RUN` happens unconditionally, because the killed instruction cannot redirect. `ST_RUN -> ST_RUN` happens otherwise. Reset places the FSM in `ST_RUN`.

Top module: `pcsel_ctl`

## Requirements
- R1: `ex_kind` encodes the six control-transfer kinds as follows: 1 is branch-if-zero, 2 is branch-if-not-zero, 3 is jump, 4 is jump-and-link, 5 is jump-register and 6 is jump-and-link-register. Codes 0 and 7 are not control transfers.
- R2: A branch-if-zero is taken exactly when `ex_rs_val` equals zero.
- R3: A branch-if-not-zero is taken exactly when `ex_rs_val` is non-zero.
- R4: For a taken branch, a jump, or a jump-and-link, `pc_sel` is 1 and `next_pc` is `ex_npc + ex_disp`, computed modulo 2^32.
- R5: For a jump-register or a jump-and-link-register, `pc_sel` is 2 and `next_pc` is `ex_rs_val`.
- R6: `pc_sel` is 0 and `next_pc` is `if_pc + 4` in three cases: a branch that is not taken, a code that is not a control transfer, or no redirect at all.
- R7: Every redirect (`pc_sel` not 0) makes `squash` go to 1 in the following cycle, for exactly one cycle.
- R8: An instruction in execute causes no redirect and no link in two cases: while `squash` is 1, or while `ex_valid` is 0.
- R9: A valid, unsquashed jump-and-link or jump-and-link-register sets `link_valid` to 1, and `link_addr` then equals `ex_npc`. All other kinds leave `link_valid` at 0.
- R10: While `rst_n` is low, and in the first cycle after it rises, `squash` is 0. Asserting reset while the FSM is in `ST_KILL` clears `squash`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_kind | input | 3 | Control-transfer kind of the execute instruction |
| ex_rs_val | input | 32 | Source register value (zero test / indirect target) |
| ex_npc | input | 32 | Execute-stage next-PC (address after the instruction) |
| ex_disp | input | 32 | Sign-extended displacement |
| if_pc | input | 32 | Current fetch PC |
| next_pc | output | 32 | Selected next fetch address |
| pc_sel | output | 2 | PC multiplexer select: 0 sequential, 1 PC-relative, 2 register-indirect |
| squash | output | 1 | Instruction now in execute is wrong-path; block its writes |
| link_valid | output | 1 | Return address must be written back |
| link_addr | output | 32 | Return address |

## Verification
The main function is exercised with a table that holds each of the six kinds, the codes that are not control transfers, and both the zero and non-zero register values for each branch. This separates the condition polarity of the two branch kinds and the two target sources, and it shows whether linking is limited to the two link-writing kinds. A negative displacement checks sign handling in the PC-relative adder. Directed tests then hold a taken jump in execute while it is squashed and while it is invalid, run a jump immediately after a jump to check that the kill lasts a single cycle, and apply reset while the FSM is in `ST_KILL`.

// File: rtl/pcsel_pkg.sv
package pcsel_pkg;

    typedef enum logic [2:0] {
        CK_NONE  = 3'd0,
        CK_BEQZ  = 3'd1,
        CK_BNEZ  = 3'd2,
        CK_JUMP  = 3'd3,
        CK_JLINK = 3'd4,
        CK_JREG  = 3'd5,
        CK_JLREG = 3'd6,
        CK_RSVD  = 3'd7
    } ctl_kind_e;

    typedef enum logic [1:0] {
        SEL_SEQ  = 2'd0,
        SEL_REL  = 2'd1,
        SEL_IND  = 2'd2,
        SEL_NONE = 2'd3
    } pc_sel_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_KILL = 1'b1
    } kill_state_e;

endpackage

// File: rtl/pcsel_decode.sv
module pcsel_decode
    import pcsel_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            act,
    input  logic [2:0]      kind,
    input  logic [XLEN-1:0] rs_val,
    output logic [1:0]      sel,
    output logic            link
);
    ctl_kind_e k;
    logic      rs_zero;

    always_comb begin
        k       = ctl_kind_e'(kind);
        rs_zero = (rs_val == '0);
        sel     = SEL_SEQ;
        link    = 1'b0;
        if (act) begin
            unique case (k)
                CK_BEQZ:  sel = rs_zero  ? SEL_REL : SEL_SEQ;
                CK_BNEZ:  sel = !rs_zero ? SEL_REL : SEL_SEQ;
                CK_JUMP:  sel = SEL_REL;
                CK_JLINK: begin sel = SEL_REL; link = 1'b1; end
                CK_JREG:  sel = SEL_IND;
                CK_JLREG: begin sel = SEL_IND; link = 1'b1; end
                default:  sel = SEL_SEQ;
            endcase
        end
    end
endmodule

// File: rtl/pcsel_target.sv
module pcsel_target
    import pcsel_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [1:0]      sel,
    input  logic [XLEN-1:0] if_pc,
    input  logic [XLEN-1:0] npc,
    input  logic [XLEN-1:0] disp,
    input  logic [XLEN-1:0] rs_val,
    output logic [XLEN-1:0] target
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] rel_pc;

    assign seq_pc = if_pc + STEP;
    assign rel_pc = npc + disp;

    always_comb begin
        unique case (pc_sel_e'(sel))
            SEL_REL: target = rel_pc;
            SEL_IND: target = rs_val;
            default: target = seq_pc;
        endcase
    end
endmodule

// File: rtl/pcsel_kill_fsm.sv
module pcsel_kill_fsm
    import pcsel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic redirect,
    output logic kill
);
    kill_state_e state_q;
    kill_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  state_d = redirect ? ST_KILL : ST_RUN;
            ST_KILL: state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_KILL: kill = 1'b1;
            default: kill = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcsel_ctl.sv
module pcsel_ctl
    import pcsel_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ex_valid,
    input  logic [2:0]      ex_kind,
    input  logic [XLEN-1:0] ex_rs_val,
    input  logic [XLEN-1:0] ex_npc,
    input  logic [XLEN-1:0] ex_disp,
    input  logic [XLEN-1:0] if_pc,
    output logic [XLEN-1:0] next_pc,
    output logic [1:0]      pc_sel,
    output logic            squash,
    output logic            link_valid,
    output logic [XLEN-1:0] link_addr
);
    logic act;
    logic redirect;

    assign act      = ex_valid && !squash;
    assign redirect = (pc_sel != SEL_SEQ);

    pcsel_decode #(.XLEN(XLEN)) u_decode (
        .act    (act),
        .kind   (ex_kind),
        .rs_val (ex_rs_val),
        .sel    (pc_sel),
        .link   (link_valid)
    );

    pcsel_target #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_target (
        .sel    (pc_sel),
        .if_pc  (if_pc),
        .npc    (ex_npc),
        .disp   (ex_disp),
        .rs_val (ex_rs_val),
        .target (next_pc)
    );

    pcsel_kill_fsm u_kill (
        .clk      (clk),
        .rst_n    (rst_n),
        .redirect (redirect),
        .kill     (squash)
    );

    assign link_addr = ex_npc;
endmodule

// File: rtl/pcsel_ctl_chk.sv
module pcsel_ctl_chk #(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ex_valid,
    input logic [XLEN-1:0] if_pc,
    input logic [XLEN-1:0] next_pc,
    input logic [1:0]      pc_sel,
    input logic            squash,
    input logic            link_valid
);
    // R7: a redirect is followed by a kill cycle
    assert_redirect_kills_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel != 2'd0) |=> squash);

    // R7: the kill lasts exactly one cycle
    assert_kill_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> !squash);

    // R8: a killed instruction neither redirects nor links
    assert_killed_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
        squash |-> (pc_sel == 2'd0 && !link_valid));

    // R8: an invalid instruction neither redirects nor links
    assert_invalid_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_valid |-> (pc_sel == 2'd0 && !link_valid));

    // R6: the sequential select delivers fetch PC plus one instruction
    assert_seq_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel == 2'd0) |-> (next_pc == if_pc + XLEN'(INSN_BYTES)));

    // R9: a link only comes with a redirect
    assert_link_redirects_R9: assert property (@(posedge clk) disable iff (!rst_n)
        link_valid |-> (pc_sel != 2'd0));
endmodule

bind pcsel_ctl pcsel_ctl_chk #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ex_valid   (ex_valid),
    .if_pc      (if_pc),
    .next_pc    (next_pc),
    .pc_sel     (pc_sel),
    .squash     (squash),
    .link_valid (link_valid)
);

// File: tb/test_pcsel_ctl.sv
`timescale 1ns/1ps
module test_pcsel_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ex_valid = 1'b0;
    logic [2:0]  ex_kind = 3'd0;
    logic [31:0] ex_rs_val = '0, ex_npc = '0, ex_disp = '0, if_pc = '0;
    logic [31:0] next_pc, link_addr;
    logic [1:0]  pc_sel;
    logic        squash, link_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pcsel_ctl i_pcsel_ctl (
        .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_kind(ex_kind),
        .ex_rs_val(ex_rs_val), .ex_npc(ex_npc), .ex_disp(ex_disp), .if_pc(if_pc),
        .next_pc(next_pc), .pc_sel(pc_sel), .squash(squash),
        .link_valid(link_valid), .link_addr(link_addr)
    );

    typedef struct packed {
        logic [2:0]  kind;
        logic [31:0] rs;
        logic [31:0] npc;
        logic [31:0] disp;
        logic [31:0] ipc;
        logic [1:0]  sel;
        logic [31:0] pc;
        logic        link;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{3'd0, 32'h0,        32'h104,  32'h40,       32'h108,  2'd0, 32'h10C,  1'b0}, // R1 non-transfer
        '{3'd1, 32'h0,        32'h1004, 32'h20,       32'h1008, 2'd1, 32'h1024, 1'b0}, // R2 taken
        '{3'd1, 32'h5,        32'h1004, 32'h20,       32'h1008, 2'd0, 32'h100C, 1'b0}, // R2 not taken
        '{3'd2, 32'hFFFFFFFF, 32'h2000, 32'hFFFFFFF0, 32'h2004, 2'd1, 32'h1FF0, 1'b0}, // R3 taken, neg disp
        '{3'd2, 32'h0,        32'h2004, 32'h10,       32'h2008, 2'd0, 32'h200C, 1'b0}, // R3 not taken
        '{3'd3, 32'h7,        32'h3000, 32'h100,      32'h3004, 2'd1, 32'h3100, 1'b0}, // R4 jump
        '{3'd4, 32'h0,        32'h3000, 32'hFFFFF000, 32'h3004, 2'd1, 32'h2000, 1'b1}, // R4 R9 jump-link
        '{3'd5, 32'h8000,     32'h4000, 32'h10,       32'h4004, 2'd2, 32'h8000, 1'b0}, // R5 jump-reg
        '{3'd6, 32'hA00,      32'h4000, 32'h0,        32'h4004, 2'd2, 32'hA00,  1'b1}, // R5 R9 jump-link-reg
        '{3'd7, 32'h0,        32'h500,  32'h80,       32'h500,  2'd0, 32'h504,  1'b0}  // R1 code 7
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [2:0] k, input logic [31:0] rs,
                         input logic [31:0] npc, input logic [31:0] disp, input logic [31:0] ipc);
        ex_valid = v; ex_kind = k; ex_rs_val = rs; ex_npc = npc; ex_disp = disp; if_pc = ipc;
    endtask

    initial begin
        #100000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        @(negedge clk); #1;
        chk("R10 squash in reset", {31'd0, squash}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        drive(1'b0, 3'd3, 32'h0, 32'h0, 32'h0, 32'h200);
        @(negedge clk); #1;
        chk("R10 squash after reset", {31'd0, squash}, 32'd0);

        // Table walk: R1..R6, R9 combinational, R7 kill next cycle
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(1'b1, TBL[i].kind, TBL[i].rs, TBL[i].npc, TBL[i].disp, TBL[i].ipc);
            #1;
            chk("R1 table pc_sel", {30'd0, pc_sel}, {30'd0, TBL[i].sel});
            chk("R4/R5/R6 table next_pc", next_pc, TBL[i].pc);
            chk("R9 table link_valid", {31'd0, link_valid}, {31'd0, TBL[i].link});
            if (TBL[i].link) chk("R9 table link_addr", link_addr, TBL[i].npc);
            @(negedge clk);
            drive(1'b0, 3'd0, 32'h0, 32'h0, 32'h0, 32'h600);
            #1;
            chk("R7 table kill after redirect", {31'd0, squash}, {31'd0, TBL[i].sel != 2'd0});
        end

        // R8: invalid jump does nothing
        @(negedge clk);
        drive(1'b0, 3'd3, 32'h0, 32'h700, 32'h40, 32'h800);
        #1;
        chk("R8 invalid pc_sel", {30'd0, pc_sel}, 32'd0);
        chk("R8 invalid next_pc", next_pc, 32'h804);
        @(negedge clk); #1;
        chk("R8 invalid no kill", {31'd0, squash}, 32'd0);

        // R7/R8: jump then killed jump-and-link-register
        drive(1'b1, 3'd3, 32'h0, 32'h900, 32'h100, 32'h904);
        #1;
        chk("R4 jump sel", {30'd0, pc_sel}, 32'd1);
        @(negedge clk);
        drive(1'b1, 3'd6, 32'hC00, 32'h904, 32'h0, 32'hA00);
        #1;
        chk("R7 kill asserted", {31'd0, squash}, 32'd1);
        chk("R8 killed no redirect", {30'd0, pc_sel}, 32'd0);
        chk("R8 killed next_pc", next_pc, 32'hA04);
        chk("R8 killed no link", {31'd0, link_valid}, 32'd0);
        @(negedge clk);
        drive(1'b0, 3'd0, 32'h0, 32'h0, 32'h0, 32'hA04);
        #1;
        chk("R7 kill one cycle", {31'd0, squash}, 32'd0);

        // R10: reset while in kill state
        @(negedge clk);
        drive(1'b1, 3'd5, 32'h1234, 32'h0, 32'h0, 32'hB00);
        @(negedge clk);
        drive(1'b0, 3'd0, 32'h0, 32'h0, 32'h0, 32'hB04);
        #1;
        chk("R7 kill before reset", {31'd0, squash}, 32'd1);
        rst_n = 1'b0; #1;
        chk("R10 reset clears kill", {31'd0, squash}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R10 stays clear", {31'd0, squash}, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule